// File: doc/BRIEF.md
# Dual-Half Timer/Counter with Capture

This block is a pair of 8-bit counting units. They run either as two separate halves or chained into one 16-bit unit. A shared programmable prescaler divides a system-clock enable into timer ticks. An external event input can drive a half, or the chained pair, directly as an event counter. A two-bit mode input selects one of four arrangements:

| `mode_sel` | Low half | High half |
|---|---|---|
| 0 | prescaled timer | prescaled timer |
| 1 | prescaled timer | event counter |
| 2 | low byte of one 16-bit prescaled timer | high byte of the same timer |
| 3 | low byte of one 16-bit event counter | high byte of the same counter |

Each counting unit compares against a writable match value. When it advances from the match value, it reloads to zero and raises a sticky flag. Each half has its own capture strobe. In the 16-bit modes, either strobe snapshots both bytes together. Software configures the block through a simple register write port and reads it through a registered read port. Two level interrupt requests follow the flags gated by per-half enables.

Register map (address, access):

| Address | Register | Access |
|---|---|---|
| 0 | prescale limit | read/write |
| 1 | low match | read/write |
| 2 | high match | read/write |
| 3 | interrupt enables, bit0 low, bit1 high | read/write |
| 4 | flags, bit0 low, bit1 high | write 1 to clear |
| 5 | low count | read only |
| 6 | high count | read only |
| 7 | low capture | read only |
| 8 | high capture | read only |

Any other address reads as zero.

Top module: `tmrp_timer_pair`

## Requirements
- R1: After synchronous reset, the following read as zero: counts, captures, flags, interrupt enables and the prescale limit. Both match registers read 0xFF. `irq_lo` and `irq_hi` are low.
- R2: The prescaler emits one tick per (limit+1) cycles in which `sys_en` is high. In mode 0, each half advances by one per tick.
- R3: In mode 0, a half that advances while equal to its match value reloads to zero and sets its flag (flags bit0 for the low half, bit1 for the high half). `evt_in` has no effect in mode 0.
- R4: In mode 1, the low half counts prescaler ticks. The high half counts cycles with `evt_in` high, and its match sets flags bit1.
- R5: In mode 2, the halves form one 16-bit prescaled timer, with the low byte carrying into the high byte. The match value is {high match, low match}. Advancing from the match value reloads both bytes to zero and sets only flags bit1.
- R6: In mode 3, the halves form one 16-bit counter of cycles with `evt_in` high, using the same 16-bit match as R5. `sys_en` has no effect in mode 3.
- R7: In modes 0 and 1, `cap_lo` copies the low count, and `cap_hi` copies the high count, as each count stands in the cycle of the strobe.
- R8: In modes 2 and 3, either strobe copies both bytes of the 16-bit count from the same cycle.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A flag set event in the same cycle as a clear leaves the flag set.
- R10: Each interrupt output is high in the cycle after its flag and its enable are both 1. It is low otherwise.
- R11: A change of `mode_sel` clears both counts and the prescaler in the following cycle.
- R12: `rd_data` is registered. It shows the register at `rd_addr` one clock after the address is applied, using the map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| sys_en | input | 1 | system-clock enable feeding the prescaler |
| evt_in | input | 1 | external event strobe, one count per high cycle |
| mode_sel | input | 2 | operating mode 0..3 |
| cap_lo | input | 1 | low half capture strobe |
| cap_hi | input | 1 | high half capture strobe |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 4 | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | 4 | register read address |
| rd_data | output | 8 | registered read data |
| irq_lo | output | 1 | low half interrupt request |
| irq_hi | output | 1 | high half interrupt request |

## Verification
The timing of each result is fixed:
- A count or flag moves on the edge that samples an enabled tick or event.
- A capture takes the count present in the strobe cycle, so it reads back as the value before that cycle's increment.
- `rd_data` follows one edge after the address.
- An interrupt follows two edges after the enable write: one edge for the enable register and one for the output register.

Stimulus is applied as an exact number of enabled cycles or event pulses with all other inputs idle. Counts are read only after activity stops, so the expected values are closed-form arithmetic on limit, match and pulse count. Interrupt levels are sampled at the falling edge after the second register stage has updated.

// File: rtl/tmrp_pkg.sv
package tmrp_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_MIXED    = 2'd1,
    MODE_WIDE_TMR = 2'd2,
    MODE_WIDE_EVT = 2'd3
  } tmr_mode_e;

  localparam int unsigned REG_PRESC = 0;
  localparam int unsigned REG_MLO   = 1;
  localparam int unsigned REG_MHI   = 2;
  localparam int unsigned REG_IEN   = 3;
  localparam int unsigned REG_FLAGS = 4;
  localparam int unsigned REG_CLO   = 5;
  localparam int unsigned REG_CHI   = 6;
  localparam int unsigned REG_KLO   = 7;
  localparam int unsigned REG_KHI   = 8;

endpackage

// File: rtl/tmrp_prescaler.sv
module tmrp_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic             at_lim;

  // >= keeps the divider from running the long way round if the limit drops
  assign at_lim = (div_q >= limit);
  assign tick   = en && at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= at_lim ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmrp_half.sv
module tmrp_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         reload,
  input  logic         cap,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap_val
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
    end else if (cap) begin
      cap_val <= cnt;
    end
  end
endmodule

// File: rtl/tmrp_timer_pair.sv
module tmrp_timer_pair
  import tmrp_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_en,
  input  logic              evt_in,
  input  logic [1:0]        mode_sel,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int unsigned NH    = 2;
  localparam int unsigned CNT_W = NH * HALF_W;

  tmr_mode_e                     mode_q;
  logic                          mode_chg;
  logic                          wide;
  logic                          lo_evt_src;
  logic                          hi_evt_src;
  logic                          pre_tick;
  logic                          lo_adv;
  logic                          hi_step;
  logic                          wide_hit;
  logic [CNT_W-1:0]              cnt16;
  logic [CNT_W-1:0]              match16;
  logic [NH-1:0][HALF_W-1:0]     cnt_v;
  logic [NH-1:0][HALF_W-1:0]     cap_v;
  logic [NH-1:0][HALF_W-1:0]     match_q;
  logic [NH-1:0]                 inc_v;
  logic [NH-1:0]                 reload_v;
  logic [NH-1:0]                 capt_v;
  logic [NH-1:0]                 set_ev;
  logic [NH-1:0]                 flag_q;
  logic [NH-1:0]                 ie_q;
  logic [NH-1:0]                 irq_q;
  logic [PRE_W-1:0]              presc_q;
  logic [HALF_W-1:0]             rd_nxt;
  logic                          wr_flags;

  // ---------------- mode tracking ----------------
  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SPLIT;
    else     mode_q <= tmr_mode_e'(mode_sel);
  end

  assign mode_chg   = (mode_sel != mode_q);
  assign wide       = (mode_q == MODE_WIDE_TMR) || (mode_q == MODE_WIDE_EVT);
  assign lo_evt_src = (mode_q == MODE_WIDE_EVT);
  assign hi_evt_src = (mode_q == MODE_MIXED) || (mode_q == MODE_WIDE_EVT);

  tmrp_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (mode_chg),
    .en    (sys_en),
    .limit (presc_q),
    .tick  (pre_tick)
  );

  // ---------------- advance / reload decisions ----------------
  assign cnt16    = {cnt_v[1], cnt_v[0]};
  assign match16  = {match_q[1], match_q[0]};
  assign lo_adv   = lo_evt_src ? evt_in : pre_tick;
  assign hi_step  = hi_evt_src ? evt_in : pre_tick;
  assign wide_hit = wide && lo_adv && (cnt16 == match16);

  assign inc_v[0]    = lo_adv;
  assign inc_v[1]    = wide ? (lo_adv && (&cnt_v[0])) : hi_step;
  assign reload_v[0] = wide ? wide_hit : (lo_adv && (cnt_v[0] == match_q[0]));
  assign reload_v[1] = wide ? wide_hit : (hi_step && (cnt_v[1] == match_q[1]));
  assign capt_v[0]   = wide ? (cap_lo || cap_hi) : cap_lo;
  assign capt_v[1]   = wide ? (cap_lo || cap_hi) : cap_hi;
  assign set_ev[0]   = !wide && reload_v[0];
  assign set_ev[1]   = reload_v[1];

  assign wr_flags = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));

  // ---------------- per-half datapath ----------------
  for (genvar g = 0; g < NH; g++) begin : g_half
    tmrp_half #(.W(HALF_W)) u_half (
      .clk     (clk),
      .rst     (rst),
      .clr     (mode_chg),
      .inc     (inc_v[g]),
      .reload  (reload_v[g]),
      .cap     (capt_v[g]),
      .cnt     (cnt_v[g]),
      .cap_val (cap_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[g] <= 1'b0;
      end else if (set_ev[g]) begin
        flag_q[g] <= 1'b1;
      end else if (wr_flags && wr_data[g]) begin
        flag_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= flag_q[g] && ie_q[g];
    end
  end

  assign irq_lo = irq_q[0];
  assign irq_hi = irq_q[1];

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      match_q <= '1;
      ie_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_PRESC)) presc_q    <= wr_data[PRE_W-1:0];
      if (wr_addr == ADDR_W'(REG_MLO))   match_q[0] <= wr_data;
      if (wr_addr == ADDR_W'(REG_MHI))   match_q[1] <= wr_data;
      if (wr_addr == ADDR_W'(REG_IEN))   ie_q       <= wr_data[NH-1:0];
    end
  end

  // ---------------- registered read port ----------------
  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      ADDR_W'(REG_PRESC): rd_nxt = HALF_W'(presc_q);
      ADDR_W'(REG_MLO):   rd_nxt = match_q[0];
      ADDR_W'(REG_MHI):   rd_nxt = match_q[1];
      ADDR_W'(REG_IEN):   rd_nxt = HALF_W'(ie_q);
      ADDR_W'(REG_FLAGS): rd_nxt = HALF_W'(flag_q);
      ADDR_W'(REG_CLO):   rd_nxt = cnt_v[0];
      ADDR_W'(REG_CHI):   rd_nxt = cnt_v[1];
      ADDR_W'(REG_KLO):   rd_nxt = cap_v[0];
      ADDR_W'(REG_KHI):   rd_nxt = cap_v[1];
      default:            rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/tmrp_chk.sv
module tmrp_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic [1:0]   mode_q,
  input logic         cap_lo,
  input logic         cap_hi,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cap_lo_val,
  input logic [W-1:0] cap_hi_val,
  input logic [1:0]   flag_q,
  input logic [1:0]   ie_q,
  input logic [1:0]   set_ev,
  input logic         irq_lo,
  input logic         irq_hi
);
  // R11
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != mode_q) |=> (cnt_lo == '0 && cnt_hi == '0));

  // R5
  wide_lo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[1] |=> !$rose(flag_q[0]));

  // R9
  flag_lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev[0] |=> flag_q[0]);

  // R9
  flag_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev[1] |=> flag_q[1]);

  // R10
  irq_lo_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo == ($past(flag_q[0]) && $past(ie_q[0])));

  // R10
  irq_hi_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi == ($past(flag_q[1]) && $past(ie_q[1])));

  // R7
  split_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[1] && cap_lo) |=> (cap_lo_val == $past(cnt_lo)));

  // R8
  wide_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && (cap_lo || cap_hi)) |=>
      ({cap_hi_val, cap_lo_val} == $past({cnt_hi, cnt_lo})));
endmodule

bind tmrp_timer_pair tmrp_chk #(.W(HALF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .mode_q     (mode_q),
  .cap_lo     (cap_lo),
  .cap_hi     (cap_hi),
  .cnt_lo     (cnt_v[0]),
  .cnt_hi     (cnt_v[1]),
  .cap_lo_val (cap_v[0]),
  .cap_hi_val (cap_v[1]),
  .flag_q     (flag_q),
  .ie_q       (ie_q),
  .set_ev     (set_ev),
  .irq_lo     (irq_lo),
  .irq_hi     (irq_hi)
);

// File: tb/tb_tmrp_timer_pair.sv
module tb_tmrp_timer_pair;
  localparam logic [3:0] A_PRESC = 4'd0, A_MLO = 4'd1, A_MHI = 4'd2, A_IEN = 4'd3,
                         A_FLAGS = 4'd4, A_CLO = 4'd5, A_CHI = 4'd6, A_KLO = 4'd7,
                         A_KHI = 4'd8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_en = 1'b0, evt_in = 1'b0, cap_lo = 1'b0, cap_hi = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_lo, irq_hi;
  int         n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  tmrp_timer_pair dut (
    .clk(clk), .rst(rst), .sys_en(sys_en), .evt_in(evt_in), .mode_sel(mode_sel),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; sys_en = 0; evt_in = 0; cap_lo = 0; cap_hi = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic run_cap(input int n, input int at_lo, input int at_hi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sys_en = 1'b1;
      cap_lo = (i == at_lo);
      cap_hi = (i == at_hi);
    end
    @(negedge clk);
    sys_en = 1'b0; cap_lo = 1'b0; cap_hi = 1'b0;
  endtask

  task automatic run_en(input int n);
    run_cap(n, -1, -1);
  endtask

  task automatic pulse_evt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    rd_chk("R1 low count", A_CLO, 0);
    rd_chk("R1 high capture", A_KHI, 0);
    rd_chk("R1 flags", A_FLAGS, 0);
    rd_chk("R1 prescale limit", A_PRESC, 0);
    rd_chk("R12 low match reset read", A_MLO, 8'hFF);
    rd_chk("R12 unmapped address", 4'hF, 0);
    chk("R1 irq_lo", int'(irq_lo), 0);
    chk("R1 irq_hi", int'(irq_hi), 0);
  endtask

  task automatic t_split();
    do_reset(2'd0);
    wr(A_PRESC, 8'd2); wr(A_MLO, 8'd4); wr(A_MHI, 8'd9);
    rd_chk("R12 high match readback", A_MHI, 9);
    run_en(18);
    rd_chk("R3 low half wrapped at match", A_CLO, 1);
    rd_chk("R2 high half six ticks", A_CHI, 6);
    rd_chk("R3 only low flag", A_FLAGS, 1);
    pulse_evt(5);
    rd_chk("R3 events ignored low", A_CLO, 1);
    rd_chk("R3 events ignored high", A_CHI, 6);
  endtask

  task automatic t_flags_irq();
    do_reset(2'd0);
    wr(A_MLO, 8'd2);
    run_en(3);
    rd_chk("R3 flag after match", A_FLAGS, 1);
    chk("R10 irq_lo off while disabled", int'(irq_lo), 0);
    wr(A_IEN, 8'd1);
    @(negedge clk);
    chk("R10 irq_lo raised", int'(irq_lo), 1);
    chk("R10 irq_hi stays low", int'(irq_hi), 0);
    wr(A_FLAGS, 8'h02);
    rd_chk("R9 zero bit leaves flag", A_FLAGS, 1);
    wr(A_FLAGS, 8'h01);
    rd_chk("R9 write one clears", A_FLAGS, 0);
    chk("R10 irq_lo dropped", int'(irq_lo), 0);
    wr(A_MLO, 8'd0);
    @(negedge clk);
    sys_en = 1'b1; wr_en = 1'b1; wr_addr = A_FLAGS; wr_data = 8'h01;
    @(negedge clk);
    sys_en = 1'b0; wr_en = 1'b0;
    rd_chk("R9 set beats clear", A_FLAGS, 1);
  endtask

  task automatic t_mixed();
    do_reset(2'd1);
    wr(A_MHI, 8'd3);
    run_en(7);
    pulse_evt(5);
    rd_chk("R4 low counts ticks", A_CLO, 7);
    rd_chk("R4 high counts events", A_CHI, 1);
    rd_chk("R4 high flag", A_FLAGS, 2);
  endtask

  task automatic t_wide_tmr();
    do_reset(2'd2);
    wr(A_PRESC, 8'd1); wr(A_MHI, 8'd1); wr(A_MLO, 8'd2);
    run_en(514);
    rd_chk("R5 carry low byte", A_CLO, 1);
    rd_chk("R5 carry high byte", A_CHI, 1);
    rd_chk("R5 no flag before match", A_FLAGS, 0);
    run_en(86);
    rd_chk("R5 wrap low byte", A_CLO, 8'h29);
    rd_chk("R5 wrap high byte", A_CHI, 0);
    rd_chk("R5 only high flag", A_FLAGS, 2);
  endtask

  task automatic t_wide_evt();
    do_reset(2'd3);
    wr(A_MHI, 8'd1); wr(A_MLO, 8'd0);
    @(negedge clk); sys_en = 1'b1;
    pulse_evt(300);
    run_en(20);
    rd_chk("R6 low byte", A_CLO, 8'h2B);
    rd_chk("R6 high byte", A_CHI, 0);
    rd_chk("R6 high flag only", A_FLAGS, 2);
  endtask

  task automatic t_capture();
    do_reset(2'd0);
    run_cap(10, 6, 8);
    rd_chk("R7 low capture", A_KLO, 6);
    rd_chk("R7 high capture", A_KHI, 8);
    rd_chk("R7 count kept running", A_CLO, 10);
    do_reset(2'd2);
    run_cap(300, -1, 259);
    rd_chk("R8 capture low byte", A_KLO, 8'h03);
    rd_chk("R8 capture high byte", A_KHI, 8'h01);
    rd_chk("R8 final high byte", A_CHI, 8'h01);
  endtask

  task automatic t_mode_change();
    do_reset(2'd0);
    wr(A_PRESC, 8'd1);
    run_en(3);
    rd_chk("R2 one tick in three enables", A_CLO, 1);
    @(negedge clk); mode_sel = 2'd1;
    @(negedge clk);
    rd_chk("R11 low cleared", A_CLO, 0);
    run_en(1);
    rd_chk("R11 prescaler restarted", A_CLO, 0);
    run_en(1);
    rd_chk("R11 tick after full period", A_CLO, 1);
  endtask

  initial begin
    #(4 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_split();
    t_flags_irq();
    t_mixed();
    t_wide_tmr();
    t_wide_evt();
    t_capture();
    t_mode_change();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule